// File: doc/BRIEF.md
# Legacy Shadow Memory Region Decoder

This block sits in a host bridge and routes each CPU memory access either to local DRAM or to the external bus. It covers four kinds of address:

- **Upper legacy area** (0xC0000 to 0xFFFFF). It is cut into sixteen 16 KB segments. Reads and writes in each segment are steered independently by four enable bytes.
- **Two fixed low holes** (0x80000 to 0x9FFFF and 0xA0000 to 0xBFFFF). Each has one bit in a hole-control byte.
- **Two 1 MB windows** at 0xE00000 and 0xF00000. They can be handed back to the external bus when installed memory reaches them.
- **Every other address**. It goes to DRAM only when it lies below the installed memory size.

Configuration arrives one byte at a time through a write-only port. Each byte is held in a register. Routing is then a combinational function of the access address, its direction and those registers. Two status outputs report whether any of the top four high-half segments (0xF0000 to 0xFFFFF) is shadowed for reads, and likewise for writes.

Top module: `shadow_route_top`

## Requirements
- R1: After reset every control byte is zero. Every legacy segment and both low holes route to the external bus, and both shadow status outputs are low.
- R2: Select code 0 writes the low-half read byte. Bit i set sends reads of 0xC0000+i*0x4000 (16 KB) to DRAM; bit i clear sends them external.
- R3: Select code 1 writes the high-half read byte. Bit i set sends reads of 0xE0000+i*0x4000 to DRAM; bit i clear sends them external.
- R4: Select codes 2 (low half) and 3 (high half) write the write-enable bytes. They steer writes to the same segments with the same bit order, independently of the read bytes.
- R5: `bios_rd_shadow` is high when any of bits 7..4 of the high-half read byte is set. `bios_wr_shadow` is high when any of bits 7..4 of the high-half write byte is set.
- R6: Select code 4 writes the hole byte. Bit 3 set routes 0xA0000-0xBFFFF to DRAM, and bit 2 set routes 0x80000-0x9FFFF to DRAM. A clear bit routes the hole external for both reads and writes.
- R7: When `mem_size_mb` is above 14, hole bit 5 clear routes 0xE00000-0xEFFFFF to DRAM and bit 5 set routes it external. When `mem_size_mb` is above 15, bit 4 does the same for 0xF00000-0xFFFFFF. Below those sizes each window is external.
- R8: Any other address goes to DRAM when its MB index (address bits above bit 19) is below `mem_size_mb`, and external otherwise.
- R9: While `acc_valid` is high exactly one of `to_dram` and `to_ext` is high. While it is low both are low.
- R10: A configuration write changes routing from the cycle after the write edge. Writes with select codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 3 | Configuration byte select code |
| cfg_wdata | input | 8 | Configuration byte value |
| mem_size_mb | input | ADDR_W-19 | Installed memory size in MB (static) |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_addr | input | ADDR_W | Access byte address |
| to_dram | output | 1 | Access routed to local DRAM |
| to_ext | output | 1 | Access routed to external bus |
| bios_rd_shadow | output | 1 | Top BIOS segments shadowed for reads |
| bios_wr_shadow | output | 1 | Top BIOS segments shadowed for writes |

## Verification
The bench builds the block with the default 24-bit address. At that width both 1 MB windows at 0xE00000 and 0xF00000 are reachable, and `mem_size_mb` can express the sizes 14, 15 and 16 that switch those windows. The sweep places segment boundary addresses in both halves for reads and writes. Directed steps then vary memory size, flip the window bits, issue writes with unused select codes, and probe the cycle in which a new byte takes effect.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

    // number of 16 KB segments in each 128 KB half of the legacy area
    localparam int unsigned SEG_PER_HALF = 8;
    localparam int unsigned SEG_TOTAL    = 2 * SEG_PER_HALF;
    localparam int unsigned SEG_SHIFT    = 14;
    localparam int unsigned CFG_BYTES    = 5;

    typedef enum logic [2:0] {
        SEL_RD_LO = 3'd0,
        SEL_RD_HI = 3'd1,
        SEL_WR_LO = 3'd2,
        SEL_WR_HI = 3'd3,
        SEL_HOLE  = 3'd4
    } cfg_sel_e;

    // bit positions inside the hole-control byte
    localparam int unsigned HOLE_BIT_8X = 2;
    localparam int unsigned HOLE_BIT_AX = 3;
    localparam int unsigned HOLE_BIT_FW = 4;
    localparam int unsigned HOLE_BIT_EW = 5;

    typedef struct packed {
        logic [7:0] hole;
        logic [7:0] wr_hi;
        logic [7:0] wr_lo;
        logic [7:0] rd_hi;
        logic [7:0] rd_lo;
    } shadow_cfg_t;

    typedef enum logic [2:0] {
        RGN_PLAIN,
        RGN_SEG,
        RGN_HOLE_8X,
        RGN_HOLE_AX,
        RGN_WIN_E,
        RGN_WIN_F
    } region_e;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    output shadow_cfg_t cfg
);

    logic [7:0] byte_q [CFG_BYTES];

    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[b] <= 8'h00;
            end else if (cfg_we && (cfg_sel == 3'(b))) begin
                byte_q[b] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg.rd_lo = byte_q[SEL_RD_LO];
        cfg.rd_hi = byte_q[SEL_RD_HI];
        cfg.wr_lo = byte_q[SEL_WR_LO];
        cfg.wr_hi = byte_q[SEL_WR_HI];
        cfg.hole  = byte_q[SEL_HOLE];
    end

endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup
    import shadow_route_pkg::*;
(
    input  logic [19:0] addr_lo,
    input  logic        is_write,
    input  shadow_cfg_t cfg,
    output logic        seg_hit,
    output logic        seg_internal
);

    localparam logic [19:0] AREA_BASE = 20'hC0000;

    logic [SEG_TOTAL-1:0] match;
    logic [SEG_TOTAL-1:0] en_rd;
    logic [SEG_TOTAL-1:0] en_wr;

    for (genvar g = 0; g < SEG_TOTAL; g++) begin : g_seg
        localparam logic [19:0] BASE = AREA_BASE + 20'(g << SEG_SHIFT);
        assign match[g] = (addr_lo[19:SEG_SHIFT] == BASE[19:SEG_SHIFT]);
        if (g < SEG_PER_HALF) begin : g_lo
            assign en_rd[g] = cfg.rd_lo[g];
            assign en_wr[g] = cfg.wr_lo[g];
        end else begin : g_hi
            assign en_rd[g] = cfg.rd_hi[g - SEG_PER_HALF];
            assign en_wr[g] = cfg.wr_hi[g - SEG_PER_HALF];
        end
    end

    always_comb begin
        seg_hit      = |match;
        seg_internal = |(match & (is_write ? en_wr : en_rd));
    end

endmodule

// File: rtl/shadow_hole_lookup.sv
module shadow_hole_lookup
    import shadow_route_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-20:0] mem_size_mb,
    input  logic [7:0]         hole,
    output region_e            region,
    output logic               hole_internal
);

    localparam int unsigned MB_W = ADDR_W - 20;

    logic [MB_W-1:0] mb_idx;
    logic            below_1m;

    always_comb begin
        mb_idx        = addr[ADDR_W-1:20];
        below_1m      = (mb_idx == '0);
        region        = RGN_PLAIN;
        hole_internal = 1'b0;
        if (below_1m && addr[19:17] == 3'b100) begin
            region        = RGN_HOLE_8X;
            hole_internal = hole[HOLE_BIT_8X];
        end else if (below_1m && addr[19:17] == 3'b101) begin
            region        = RGN_HOLE_AX;
            hole_internal = hole[HOLE_BIT_AX];
        end else if (mb_idx == MB_W'(14) && mem_size_mb > (MB_W+1)'(14)) begin
            region        = RGN_WIN_E;
            hole_internal = !hole[HOLE_BIT_EW];
        end else if (mb_idx == MB_W'(15) && mem_size_mb > (MB_W+1)'(15)) begin
            region        = RGN_WIN_F;
            hole_internal = !hole[HOLE_BIT_FW];
        end
    end

endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
    import shadow_route_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-20:0] mem_size_mb,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              to_dram,
    output logic              to_ext,
    output logic              bios_rd_shadow,
    output logic              bios_wr_shadow
);

    localparam int unsigned MB_W = ADDR_W - 20;

    shadow_cfg_t cfg;
    region_e     hole_rgn;
    logic        hole_int;
    logic        seg_hit;
    logic        seg_int;
    logic        below_1m;
    logic        plain_int;
    logic        internal;

    shadow_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    shadow_seg_lookup u_seg (
        .addr_lo      (acc_addr[19:0]),
        .is_write     (acc_write),
        .cfg          (cfg),
        .seg_hit      (seg_hit),
        .seg_internal (seg_int)
    );

    shadow_hole_lookup #(.ADDR_W(ADDR_W)) u_hole (
        .addr          (acc_addr),
        .mem_size_mb   (mem_size_mb),
        .hole          (cfg.hole),
        .region        (hole_rgn),
        .hole_internal (hole_int)
    );

    always_comb begin
        below_1m  = (acc_addr[ADDR_W-1:20] == '0);
        plain_int = ({1'b0, acc_addr[ADDR_W-1:20]} < mem_size_mb);
        if (below_1m && seg_hit) begin
            internal = seg_int;
        end else if (hole_rgn != RGN_PLAIN) begin
            internal = hole_int;
        end else begin
            internal = plain_int;
        end
        to_dram        = acc_valid && internal;
        to_ext         = acc_valid && !internal;
        bios_rd_shadow = |cfg.rd_hi[7:4];
        bios_wr_shadow = |cfg.wr_hi[7:4];
    end

endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic [7:0]        cfg_wdata,
    input logic [ADDR_W-20:0] mem_size_mb,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              to_dram,
    input logic              to_ext,
    input logic              bios_rd_shadow,
    input logic              bios_wr_shadow
);

    assert_one_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({to_dram, to_ext}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !to_dram && !to_ext);

    assert_status_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd1) |=> (bios_rd_shadow == |$past(cfg_wdata[7:4])));

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(bios_rd_shadow) && $stable(bios_wr_shadow));

    assert_window_small_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[ADDR_W-1:20] == (ADDR_W-20)'(14)
         && mem_size_mb <= (ADDR_W-19)'(14)) |-> to_ext);

    assert_reset_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(cfg_we)) |-> !bios_rd_shadow && !bios_wr_shadow);

endmodule

bind shadow_route_top shadow_route_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_sel        (cfg_sel),
    .cfg_wdata      (cfg_wdata),
    .mem_size_mb    (mem_size_mb),
    .acc_valid      (acc_valid),
    .acc_addr       (acc_addr),
    .to_dram        (to_dram),
    .to_ext         (to_ext),
    .bios_rd_shadow (bios_rd_shadow),
    .bios_wr_shadow (bios_wr_shadow)
);

// File: tb/sim_shadow_route_top.sv
module sim_shadow_route_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int NVEC       = 20;

    // {addr[23:0], write, expect_dram}
    localparam logic [25:0] VEC [NVEC] = '{
        {24'h0C0000, 1'b0, 1'b1},
        {24'h0C4000, 1'b0, 1'b0},
        {24'h0CBFFF, 1'b0, 1'b1},
        {24'h0C4000, 1'b1, 1'b1},
        {24'h0C0000, 1'b1, 1'b0},
        {24'h0CC000, 1'b1, 1'b1},
        {24'h0DC000, 1'b0, 1'b0},
        {24'h0F0000, 1'b0, 1'b1},
        {24'h0FFFFF, 1'b0, 1'b1},
        {24'h0E0000, 1'b0, 1'b0},
        {24'h0E0000, 1'b1, 1'b1},
        {24'h0F0000, 1'b1, 1'b0},
        {24'h0A0000, 1'b0, 1'b1},
        {24'h0BFFFF, 1'b1, 1'b1},
        {24'h080000, 1'b0, 1'b0},
        {24'h09FFFF, 1'b1, 1'b0},
        {24'hE00000, 1'b0, 1'b1},
        {24'hF00010, 1'b1, 1'b1},
        {24'h100000, 1'b0, 1'b1},
        {24'h07FFFF, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [4:0]        mem_size_mb = 5'd16;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              to_dram, to_ext, bios_rd_shadow, bios_wr_shadow;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_route_top #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_size_mb(mem_size_mb), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .to_dram(to_dram),
        .to_ext(to_ext), .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // apply an access and check the routing; the outputs are combinational
    task automatic probe(input string req, input logic [ADDR_W-1:0] a,
                         input logic wr, input logic exp_dram);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        #1;
        chk(req, to_dram, exp_dram);
        chk(req, to_ext, !exp_dram);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", bios_rd_shadow, 1'b0);
        chk("R1", bios_wr_shadow, 1'b0);
        probe("R1", 24'h0C0000, 1'b0, 1'b0);
        probe("R1", 24'h0FC000, 1'b1, 1'b0);
        probe("R1", 24'h0A0000, 1'b0, 1'b0);
        // R9: idle access
        acc_valid = 1'b0; #1;
        chk("R9", to_dram, 1'b0);
        chk("R9", to_ext, 1'b0);

        cfg_write(3'd0, 8'h05);
        cfg_write(3'd1, 8'h90);
        cfg_write(3'd2, 8'h0A);
        cfg_write(3'd3, 8'h01);
        cfg_write(3'd4, 8'h08);

        // R2 R3 R4 R6 R7 R8 table sweep
        for (int i = 0; i < NVEC; i++) begin
            probe("R2/R3/R4/R6/R7/R8 sweep", VEC[i][25:2], VEC[i][1], VEC[i][0]);
        end

        // R5: status bits
        chk("R5", bios_rd_shadow, 1'b1);
        chk("R5", bios_wr_shadow, 1'b0);
        cfg_write(3'd3, 8'h20);
        chk("R5", bios_wr_shadow, 1'b1);

        // R7 and R8 with smaller memory
        mem_size_mb = 5'd14;
        probe("R7", 24'hE00000, 1'b0, 1'b0);
        probe("R7", 24'hF00000, 1'b0, 1'b0);
        probe("R8", 24'hD00000, 1'b0, 1'b1);
        mem_size_mb = 5'd15;
        probe("R7", 24'hE00000, 1'b1, 1'b1);
        probe("R7", 24'hF00000, 1'b1, 1'b0);
        mem_size_mb = 5'd16;
        cfg_write(3'd4, 8'h28);
        probe("R7", 24'hE00000, 1'b0, 1'b0);
        probe("R7", 24'hF00000, 1'b0, 1'b1);
        mem_size_mb = 5'd0;
        probe("R8", 24'h000100, 1'b0, 1'b0);
        mem_size_mb = 5'd16;

        // R10: unused selects change nothing
        cfg_write(3'd5, 8'hFF);
        cfg_write(3'd6, 8'hFF);
        cfg_write(3'd7, 8'hFF);
        probe("R10", 24'h0C4000, 1'b0, 1'b0);
        probe("R10", 24'h0080000, 1'b0, 1'b0);
        chk("R10", bios_rd_shadow, 1'b1);

        // R10: timing of a new byte
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 24'h0C4000; acc_write = 1'b0;
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 8'h02;
        #1;
        chk("R10 before edge", to_dram, 1'b0);
        @(posedge clk); #1;
        chk("R10 after edge", to_dram, 1'b1);
        cfg_we = 1'b0;

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        probe("R1", 24'h0C4000, 1'b0, 1'b0);
        chk("R1", bios_rd_shadow, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule